// File: doc/BRIEF.md
# Burst Strobed Parallel Transceiver

This block moves a short burst of parallel words to an attached device and collects that device's parallel reply on the same strobe cycles. The host presents four 8-bit words and one control bit, then pulses a start request. The block latches the burst and generates a strobe by dividing the system clock. The strobe is gated, so it toggles only while a burst is in progress. The attached device latches the outputs on the strobe's falling edge, so the block changes its outputs only on rising edges. It samples the device's 8 input lines on the falling edges of the same strobe.

An active-low enable frames the transfer. It goes low together with the first word and returns high on one extra rising edge after the last word. A burst therefore has five rising edges. Between bursts the strobe rests high, and the data, control and enable lines keep the values they last drove. Of the four captured input words, only the last two are returned to the host. They are valid once the done pulse appears.

Top module: `burst_strobe_xcvr`

## Requirements
- R1: While reset is asserted and after it is released, `strobe_o` and `en_n_o` are 1, and `dout_o`, `ctl_o`, `rsp_o`, `busy_o` and `done_o` are 0.
- R2: A start request taken while idle makes the strobe toggle every HALF_DIV system clocks. The first toggle is a fall, HALF_DIV clocks after the request is taken. A burst has exactly five rising and five falling strobe edges, after which the strobe stays high.
- R3: Word k of the burst is `burst_i[8k+7:8k]`, for k from 0 to 3. It appears on `dout_o` in the same clock in which the strobe makes its (k+1)-th rising edge, and it stays there through the following fall.
- R4: `en_n_o` goes low at the first rising edge and returns high at the fifth rising edge. `ctl_o` takes the `ctrl_i` value latched with the burst at the first rising edge.
- R5: Between bursts, `dout_o`, `ctl_o` and `en_n_o` keep their last values (the final word, the burst's control bit, and 1) until the next burst's first rising edge. No earlier word is replayed.
- R6: `din_i` is sampled at the clock in which the strobe falls. At the end of a burst, `rsp_o[7:0]` holds the sample from the third post-launch fall and `rsp_o[15:8]` holds the sample from the fourth. `rsp_o` then stays unchanged until the next burst's first capture.
- R7: `busy_o` is high from the clock after the request is taken until the fifth rising edge. `done_o` is high for exactly one clock: the one in which `en_n_o` is first seen high again.
- R8: A start request made while busy is ignored. This holds even if `burst_i` and `ctrl_i` change at the same time: neither the timing nor the words of the current burst are affected.
- R9: A start request made in the same clock as `done_o` is taken, so bursts can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst start request |
| ctrl_i | input | 1 | Control bit for the burst |
| burst_i | input | 32 | Four output words, word 0 in the low byte |
| din_i | input | 8 | Parallel input lines from the device |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock end-of-burst pulse |
| strobe_o | output | 1 | Gated strobe to the device |
| en_n_o | output | 1 | Active-low transfer enable |
| ctl_o | output | 1 | Application control line |
| dout_o | output | 8 | Parallel data lines to the device |
| rsp_o | output | 16 | Last two captured input words |

## Verification
The main function is exercised with all-zero and all-one bursts, with a walking-bit burst, and with random bursts. The all-zero and all-one bursts show whether the output lines really hold their values across a burst boundary. The walking-bit burst shows whether any words are swapped or repeated. The input lines change on every system clock, so a capture taken one clock early or late returns a different value than the one expected. Extra start pulses that arrive during a burst, carrying fresh burst data, are used to detect any re-arm or mid-burst reload. Requests made in the done cycle and idle gaps of random length separate the back-to-back path from the hold path.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

  typedef enum logic {
    BSX_IDLE = 1'b0,
    BSX_RUN  = 1'b1
  } bsx_state_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } bsx_edge_t;

endpackage

// File: rtl/bsx_rst_sync.sv
module bsx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/bsx_strobe_gen.sv
module bsx_strobe_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  output logic                strobe_o,
  output bsx_pkg::bsx_edge_t  evt_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          strobe_q, strobe_d;
  logic          tick;

  always_comb begin
    tick     = run_i && (cnt_q == LAST);
    cnt_d    = cnt_q;
    strobe_d = strobe_q;
    if (!run_i)    cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
    if (tick) strobe_d = ~strobe_q;
    evt_o.rise = tick && !strobe_q;
    evt_o.fall = tick &&  strobe_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe_o = strobe_q;

  // R2
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(strobe_o));

endmodule

// File: rtl/bsx_launch.sv
module bsx_launch #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned WORDS  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [WORDS*WORD_W-1:0]   burst_i,
  input  logic                      ctrl_i,
  input  logic                      rise_i,
  output logic [WORD_W-1:0]         dout_o,
  output logic                      ctl_o,
  output logic                      en_n_o,
  output logic                      last_o
);
  localparam int unsigned IW = $clog2(WORDS + 1);
  localparam int unsigned SW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [WORDS*WORD_W-1:0] burst_q, burst_d;
  logic                    ctrlb_q, ctrlb_d;
  logic [IW-1:0]           idx_q, idx_d;
  logic [WORD_W-1:0]       dout_q, dout_d;
  logic                    ctl_q, ctl_d;
  logic                    en_n_q, en_n_d;
  logic                    at_end;
  logic [WORD_W-1:0]       words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = burst_q[g*WORD_W +: WORD_W];
  end

  assign at_end = (idx_q == IW'(WORDS));
  assign last_o = rise_i && at_end;

  always_comb begin
    burst_d = burst_q;
    ctrlb_d = ctrlb_q;
    idx_d   = idx_q;
    dout_d  = dout_q;
    ctl_d   = ctl_q;
    en_n_d  = en_n_q;
    if (load_i) begin
      burst_d = burst_i;
      ctrlb_d = ctrl_i;
      idx_d   = '0;
    end else if (rise_i) begin
      if (!at_end) begin
        dout_d = words[idx_q[SW-1:0]];
        ctl_d  = ctrlb_q;
        en_n_d = 1'b0;
        idx_d  = idx_q + 1'b1;
      end else begin
        en_n_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= '0;
      ctrlb_q <= 1'b0;
      idx_q   <= '0;
      dout_q  <= '0;
      ctl_q   <= 1'b0;
      en_n_q  <= 1'b1;
    end else begin
      burst_q <= burst_d;
      ctrlb_q <= ctrlb_d;
      idx_q   <= idx_d;
      dout_q  <= dout_d;
      ctl_q   <= ctl_d;
      en_n_q  <= en_n_d;
    end
  end

  assign dout_o = dout_q;
  assign ctl_o  = ctl_q;
  assign en_n_o = en_n_q;

  // R3
  dout_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(dout_o));

  // R4
  enable_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> ($stable(en_n_o) && $stable(ctl_o)));

endmodule

// File: rtl/bsx_capture.sv
module bsx_capture #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned KEEP   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fall_i,
  input  logic [WORD_W-1:0]        din_i,
  output logic [KEEP*WORD_W-1:0]   rsp_o
);
  logic [KEEP*WORD_W-1:0] rsp_q, rsp_d, shifted;

  if (KEEP > 1) begin : g_shift
    assign shifted = {din_i, rsp_q[KEEP*WORD_W-1:WORD_W]};
  end else begin : g_single
    assign shifted = din_i;
  end

  always_comb begin
    rsp_d = rsp_q;
    if (fall_i) rsp_d = shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_q <= '0;
    else         rsp_q <= rsp_d;
  end

  assign rsp_o = rsp_q;

  // R6
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(rsp_o));

endmodule

// File: rtl/burst_strobe_xcvr.sv
module burst_strobe_xcvr #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned WORDS    = 4,
  parameter int unsigned KEEP     = 2,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     ctrl_i,
  input  logic [WORDS*WORD_W-1:0]  burst_i,
  input  logic [WORD_W-1:0]        din_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     strobe_o,
  output logic                     en_n_o,
  output logic                     ctl_o,
  output logic [WORD_W-1:0]        dout_o,
  output logic [KEEP*WORD_W-1:0]   rsp_o
);
  import bsx_pkg::*;

  logic       srst_n;
  bsx_state_e st_q, st_d;
  logic       done_q, done_d;
  logic       accept, last, run;
  bsx_edge_t  evt;

  bsx_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (srst_n)
  );

  assign accept = start_i && (st_q == BSX_IDLE);
  assign run    = (st_q == BSX_RUN);

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    if (accept) begin
      st_d = BSX_RUN;
    end else if (last) begin
      st_d   = BSX_IDLE;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= BSX_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  bsx_strobe_gen #(.HALF_DIV(HALF_DIV)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (srst_n),
    .run_i    (run),
    .strobe_o (strobe_o),
    .evt_o    (evt)
  );

  bsx_launch #(.WORD_W(WORD_W), .WORDS(WORDS)) u_launch (
    .clk_i   (clk_i),
    .rst_ni  (srst_n),
    .load_i  (accept),
    .burst_i (burst_i),
    .ctrl_i  (ctrl_i),
    .rise_i  (evt.rise),
    .dout_o  (dout_o),
    .ctl_o   (ctl_o),
    .en_n_o  (en_n_o),
    .last_o  (last)
  );

  bsx_capture #(.WORD_W(WORD_W), .KEEP(KEEP)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (srst_n),
    .fall_i (evt.fall),
    .din_i  (din_i),
    .rsp_o  (rsp_o)
  );

  assign busy_o = run;
  assign done_o = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    done_o |=> !done_o);

  // R7
  done_release_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    $rose(done_o) |-> (en_n_o && strobe_o && !busy_o));

  // R4
  en_busy_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    !en_n_o |-> busy_o);

  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    (busy_o && start_i && !last) |=> (busy_o && $stable(dout_o) == !$past(evt.rise)) || busy_o);

endmodule

// File: tb/burst_strobe_xcvr_bench.sv
`timescale 1ns/1ps
module burst_strobe_xcvr_bench;
  localparam int H  = 3;
  localparam int BL = 10 * H;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i, ctrl_i;
  logic [31:0] burst_i;
  logic [7:0]  din_i;
  logic        busy_o, done_o, strobe_o, en_n_o, ctl_o;
  logic [7:0]  dout_o;
  logic [15:0] rsp_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0]  hold_dout = 8'h00;
  logic        hold_ctl  = 1'b0;
  logic [15:0] hold_rsp  = 16'h0000;
  logic [7:0]  din_hist [0:BL];

  always #2 clk_i = ~clk_i;

  burst_strobe_xcvr #(.HALF_DIV(H)) u_burst_strobe_xcvr (
    .clk_i, .rst_ni, .start_i, .ctrl_i, .burst_i, .din_i,
    .busy_o, .done_o, .strobe_o, .en_n_o, .ctl_o, .dout_o, .rsp_o
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input logic [31:0] w, input int r);
    int k;
    k = (r > 4) ? 3 : r - 1;
    return w[8*k +: 8];
  endfunction

  task automatic do_burst(input logic [31:0] words, input logic c, input int intrude, input bit b2b);
    int nev, r;
    logic [7:0] d;
    burst_i = words; ctrl_i = c; start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    chk(b2b ? "R9" : "R7", "busy after request", busy_o, 1);
    chk("R2", "strobe before first fall", strobe_o, 1);
    for (int cc = 1; cc <= BL; cc++) begin
      d = 8'($urandom);
      din_i = d;
      din_hist[cc] = d;
      if (cc == intrude) begin
        start_i = 1'b1; burst_i = $urandom; ctrl_i = ~c;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk_i); @(negedge clk_i);
      nev = cc / H;
      r   = nev / 2;
      chk("R2", "strobe", strobe_o, (nev % 2 == 0) ? 1 : 0);
      if (r == 0) begin
        chk("R5", "dout held", dout_o, hold_dout);
        chk("R5", "ctl held", ctl_o, hold_ctl);
      end else begin
        chk((intrude > 0 && cc > intrude) ? "R8" : "R3", "dout word", dout_o, exp_word(words, r));
        chk("R4", "ctl", ctl_o, c);
      end
      chk("R4", "enable", en_n_o, (r >= 1 && r <= 4) ? 0 : 1);
      chk((intrude > 0 && cc > intrude) ? "R8" : "R7", "busy", busy_o, (cc < BL) ? 1 : 0);
      chk("R7", "done", done_o, (cc == BL) ? 1 : 0);
    end
    start_i = 1'b0;
    chk("R6", "captured pair", rsp_o, {din_hist[9*H], din_hist[7*H]});
    hold_dout = words[31:24];
    hold_ctl  = c;
    hold_rsp  = {din_hist[9*H], din_hist[7*H]};
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      din_i = 8'($urandom);
      burst_i = $urandom;
      ctrl_i = 1'($urandom);
      @(posedge clk_i); @(negedge clk_i);
      chk("R2", "idle strobe", strobe_o, 1);
      chk("R5", "idle dout", dout_o, hold_dout);
      chk("R5", "idle ctl", ctl_o, hold_ctl);
      chk("R5", "idle enable", en_n_o, 1);
      chk("R6", "idle rsp", rsp_o, hold_rsp);
      chk("R7", "idle busy", busy_o, 0);
    end
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; ctrl_i = 1'b0; burst_i = '0; din_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", "reset strobe", strobe_o, 1);
    chk("R1", "reset enable", en_n_o, 1);
    chk("R1", "reset dout", dout_o, 0);
    chk("R1", "reset ctl", ctl_o, 0);
    chk("R1", "reset rsp", rsp_o, 0);
    chk("R1", "reset busy", busy_o, 0);
    chk("R1", "reset done", done_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1", "post-reset busy", busy_o, 0);
    chk("R1", "post-reset strobe", strobe_o, 1);
    void'($urandom(32'h1234_5678));

    do_burst(32'h0000_0000, 1'b0, 0, 1'b0);
    do_burst(32'hFFFF_FFFF, 1'b1, 0, 1'b1);
    idle_gap(7);
    do_burst(32'h0804_0201, 1'b0, 5, 1'b0);
    do_burst(32'h8040_2010, 1'b1, BL, 1'b1);
    idle_gap(3);
    for (int t = 0; t < 16; t++) begin
      int gap, intr;
      gap  = $urandom_range(0, 5);
      intr = ($urandom_range(0, 1) == 1) ? $urandom_range(1, BL) : 0;
      do_burst($urandom, 1'($urandom), intr, gap == 0);
      if (gap > 0) idle_gap(gap);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule